// File: doc/BRIEF.md
# Sectored Almost-Full / Almost-Empty Status Bus

This block watches the fill levels of sixteen queues and turns them into almost-full and almost-empty indications. Each queue has its own pair of programmable thresholds. The block reports all of these flags through two narrow status buses, each 8 bits wide. The almost-full bus runs on the write clock and the almost-empty bus runs on the read clock. Each bus shows one sector of eight queues at a time. Sector 0 covers queues 0 to 7 and sector 1 covers queues 8 to 15.

A single mode input applies to both buses. In polled mode, each bus moves on to the next sector at every rising edge of its own clock, so a monitor sees every queue within two cycles. In direct mode, the sector on the almost-full bus comes from a write-side select input, and the sector on the almost-empty bus comes from a read-side select input. A sector number output goes with each bus, so downstream logic knows which queues the eight bits describe. Queues beyond the configured count always read as inactive.

Top module: `qfs_status_bus`

## Requirements
- R1: A synchronous active-high reset on each clock sets that clock's bus to all ones (every flag inactive) and its sector output to 0. The polled sequence of that bus restarts at sector 0.
- R2: The almost-full flag of queue q is active (driven 0) when its free space is less than or equal to its almost-full offset. Free space is 512 minus the level, and is 0 when the level is 512 or more.
- R3: The almost-empty flag of queue q is active (driven 0) when its level is less than or equal to its almost-empty offset.
- R4: When a bus shows sector s, bit b shows queue s*8+b. The sector output carries s.
- R5: Both buses have one register stage. After a rising edge of its clock, a bus reflects the levels, offsets, configured count and selection sampled at that edge.
- R6: In polled mode (direct_mode=0), the first edge after reset shows sector 0. Each further edge of that bus's clock alternates the sector (0, 1, 0, ...). This holds whatever number of queues is configured.
- R7: In direct mode (direct_mode=1), the almost-full bus shows the sector given by wr_sector_sel and the almost-empty bus shows the sector given by rd_sector_sel. The two selections are independent.
- R8: A queue whose index is at or above cfg_qcount drives 1 on both buses, whatever its level and offsets.
- R9: The almost-full outputs change only on wr_clk edges and the almost-empty outputs change only on rd_clk edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Clock of the almost-full bus |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| rd_clk | input | 1 | Clock of the almost-empty bus |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| direct_mode | input | 1 | 0 selects polled mode, 1 selects direct mode, for both buses |
| cfg_qcount | input | 5 | Number of queues in use (0 to 16) |
| q_level | input | 160 | Ten-bit word count per queue; queue q at bits q*10 and up |
| af_offset | input | 160 | Ten-bit almost-full offset per queue, same layout |
| ae_offset | input | 160 | Ten-bit almost-empty offset per queue, same layout |
| wr_sector_sel | input | 1 | Sector for the almost-full bus in direct mode |
| rd_sector_sel | input | 1 | Sector for the almost-empty bus in direct mode |
| af_bus_n | output | 8 | Active-low almost-full flags of the shown sector |
| af_sector | output | 1 | Sector shown on af_bus_n |
| ae_bus_n | output | 8 | Active-low almost-empty flags of the shown sector |
| ae_sector | output | 1 | Sector shown on ae_bus_n |

## Verification
Random levels are drawn so that many of them land exactly on a threshold, one word either side of it, or above the capacity. This separates an at-or-below comparison from a strict one, and tells whether free space saturates at zero or wraps. Polled runs with 16, 12, 5 and 0 configured queues show whether the sector walk depends on the configured count and whether unused bits stay high in both sectors. Direct runs with independent write and read selections show whether the two buses are wired to their own selects. Single-clock bursts on one side show whether a bus moves on the other side's clock.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

    localparam int NUM_Q   = 16;
    localparam int BUS_W   = 8;
    localparam int QCAP    = 512;
    localparam int NUM_SEC = NUM_Q / BUS_W;
    localparam int SEC_W   = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1;
    localparam int LVL_W   = $clog2(QCAP + 1);
    localparam int QCNT_W  = $clog2(NUM_Q + 1);

    typedef enum logic {
        MODE_POLLED = 1'b0,
        MODE_DIRECT = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic [SEC_W-1:0] sector;
        logic [BUS_W-1:0] flags_n;
    } bus_view_t;

    // Room left in a queue; saturates at zero for over-range levels.
    function automatic logic [LVL_W-1:0] free_words(input logic [LVL_W-1:0] lvl);
        if (lvl >= LVL_W'(QCAP))
            return '0;
        return LVL_W'(QCAP) - lvl;
    endfunction

    function automatic logic [SEC_W-1:0] next_sector(input logic [SEC_W-1:0] s);
        if (s == SEC_W'(NUM_SEC - 1))
            return '0;
        return s + 1'b1;
    endfunction

endpackage

// File: rtl/qfs_flag_gen.sv
module qfs_flag_gen
    import qfs_pkg::*;
(
    input  logic [QCNT_W-1:0]      cfg_qcount,
    input  logic [NUM_Q*LVL_W-1:0] q_level,
    input  logic [NUM_Q*LVL_W-1:0] af_offset,
    input  logic [NUM_Q*LVL_W-1:0] ae_offset,
    output logic [NUM_Q-1:0]       af_n,
    output logic [NUM_Q-1:0]       ae_n
);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        logic [LVL_W-1:0] lvl;
        logic [LVL_W-1:0] afo;
        logic [LVL_W-1:0] aeo;
        logic             in_use;

        assign lvl    = q_level[q*LVL_W +: LVL_W];
        assign afo    = af_offset[q*LVL_W +: LVL_W];
        assign aeo    = ae_offset[q*LVL_W +: LVL_W];
        assign in_use = cfg_qcount > QCNT_W'(q);

        assign af_n[q] = ~(in_use && (free_words(lvl) <= afo));
        assign ae_n[q] = ~(in_use && (lvl <= aeo));
    end

endmodule

// File: rtl/qfs_sector_mux.sv
module qfs_sector_mux
    import qfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_mode_e        mode,
    input  logic [SEC_W-1:0] sel,
    input  logic [NUM_Q-1:0] flags_n,
    output logic [BUS_W-1:0] bus_n,
    output logic [SEC_W-1:0] sector
);

    logic [SEC_W-1:0] ptr;
    logic [SEC_W-1:0] pick;
    bus_view_t        nxt;
    bus_view_t        cur;

    always_comb begin
        pick        = (mode == MODE_DIRECT) ? sel : ptr;
        nxt.sector  = pick;
        nxt.flags_n = '1;
        for (int s = 0; s < NUM_SEC; s++) begin
            if (pick == SEC_W'(s))
                nxt.flags_n = flags_n[s*BUS_W +: BUS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr         <= '0;
            cur.sector  <= '0;
            cur.flags_n <= '1;
        end else begin
            cur <= nxt;
            if (mode == MODE_POLLED)
                ptr <= next_sector(ptr);
        end
    end

    assign bus_n  = cur.flags_n;
    assign sector = cur.sector;

endmodule

// File: rtl/qfs_status_bus.sv
module qfs_status_bus
    import qfs_pkg::*;
(
    input  logic                   wr_clk,
    input  logic                   wr_rst,
    input  logic                   rd_clk,
    input  logic                   rd_rst,
    input  logic                   direct_mode,
    input  logic [QCNT_W-1:0]      cfg_qcount,
    input  logic [NUM_Q*LVL_W-1:0] q_level,
    input  logic [NUM_Q*LVL_W-1:0] af_offset,
    input  logic [NUM_Q*LVL_W-1:0] ae_offset,
    input  logic [SEC_W-1:0]       wr_sector_sel,
    input  logic [SEC_W-1:0]       rd_sector_sel,
    output logic [BUS_W-1:0]       af_bus_n,
    output logic [SEC_W-1:0]       af_sector,
    output logic [BUS_W-1:0]       ae_bus_n,
    output logic [SEC_W-1:0]       ae_sector
);

    bus_mode_e        mode;
    logic [NUM_Q-1:0] af_n;
    logic [NUM_Q-1:0] ae_n;

    assign mode = bus_mode_e'(direct_mode);

    qfs_flag_gen u_flags (
        .cfg_qcount (cfg_qcount),
        .q_level    (q_level),
        .af_offset  (af_offset),
        .ae_offset  (ae_offset),
        .af_n       (af_n),
        .ae_n       (ae_n)
    );

    qfs_sector_mux u_af_mux (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .mode    (mode),
        .sel     (wr_sector_sel),
        .flags_n (af_n),
        .bus_n   (af_bus_n),
        .sector  (af_sector)
    );

    qfs_sector_mux u_ae_mux (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .mode    (mode),
        .sel     (rd_sector_sel),
        .flags_n (ae_n),
        .bus_n   (ae_bus_n),
        .sector  (ae_sector)
    );

endmodule

// File: rtl/qfs_status_bus_chk.sv
module qfs_status_bus_chk
    import qfs_pkg::*;
(
    input logic                   wr_clk,
    input logic                   wr_rst,
    input logic                   rd_clk,
    input logic                   rd_rst,
    input logic                   direct_mode,
    input logic [QCNT_W-1:0]      cfg_qcount,
    input logic [NUM_Q*LVL_W-1:0] q_level,
    input logic [NUM_Q*LVL_W-1:0] af_offset,
    input logic [NUM_Q*LVL_W-1:0] ae_offset,
    input logic [SEC_W-1:0]       wr_sector_sel,
    input logic [SEC_W-1:0]       rd_sector_sel,
    input logic [BUS_W-1:0]       af_bus_n,
    input logic [SEC_W-1:0]       af_sector,
    input logic [BUS_W-1:0]       ae_bus_n,
    input logic [SEC_W-1:0]       ae_sector
);

    logic wr_seen, wr_seen2, rd_seen, rd_seen2;

    always_ff @(posedge wr_clk) begin
        wr_seen  <= !wr_rst;
        wr_seen2 <= !wr_rst && wr_seen;
    end

    always_ff @(posedge rd_clk) begin
        rd_seen  <= !rd_rst;
        rd_seen2 <= !rd_rst && rd_seen;
    end

    // R1
    af_reset_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $past(wr_rst) |-> (af_bus_n == '1 && af_sector == '0));

    // R1
    ae_reset_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $past(rd_rst) |-> (ae_bus_n == '1 && ae_sector == '0));

    // R6
    af_polled_alt_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_seen2 && !direct_mode && !$past(direct_mode)) |-> af_sector != $past(af_sector));

    // R6
    ae_polled_alt_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_seen2 && !direct_mode && !$past(direct_mode)) |-> ae_sector != $past(ae_sector));

    // R7
    af_direct_sel_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_seen && direct_mode) |-> af_sector == $past(wr_sector_sel));

    // R7
    ae_direct_sel_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_seen && direct_mode) |-> ae_sector == $past(rd_sector_sel));

    // R8
    af_unused_high_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_seen && $past(cfg_qcount) <= QCNT_W'(BUS_W) && af_sector != '0) |-> af_bus_n == '1);

    // R8
    ae_unused_high_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_seen && $past(cfg_qcount) <= QCNT_W'(BUS_W) && ae_sector != '0) |-> ae_bus_n == '1);

endmodule

bind qfs_status_bus qfs_status_bus_chk u_chk (.*);

// File: tb/qfs_status_bus_tb.sv
module qfs_status_bus_tb;
    import qfs_pkg::*;

    logic                   wr_clk = 0, rd_clk = 0;
    logic                   wr_rst = 1, rd_rst = 1;
    logic                   direct_mode = 0;
    logic [QCNT_W-1:0]      cfg_qcount = QCNT_W'(NUM_Q);
    logic [NUM_Q*LVL_W-1:0] q_level = '0, af_offset = '0, ae_offset = '0;
    logic [SEC_W-1:0]       wr_sector_sel = '0, rd_sector_sel = '0;
    logic [BUS_W-1:0]       af_bus_n, ae_bus_n;
    logic [SEC_W-1:0]       af_sector, ae_sector;

    qfs_status_bus u_dut (.*);

    int lvl [NUM_Q];
    int afo [NUM_Q];
    int aeo [NUM_Q];
    int n_chk = 0, n_fail = 0;
    int wptr = 0, rptr = 0;
    logic [BUS_W-1:0] e_af_bus = '1, e_ae_bus = '1;
    int e_af_sec = 0, e_ae_sec = 0;
    bit done = 0;

    function automatic logic [BUS_W-1:0] exp_bus(input bit is_af, input int sec);
        logic [BUS_W-1:0] r;
        for (int b = 0; b < BUS_W; b++) begin
            int q = sec * BUS_W + b;
            int fr = (lvl[q] >= QCAP) ? 0 : QCAP - lvl[q];
            bit on = (q < int'(cfg_qcount)) &&
                     (is_af ? (fr <= afo[q]) : (lvl[q] <= aeo[q]));
            r[b] = !on;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive();
        for (int q = 0; q < NUM_Q; q++) begin
            q_level[q*LVL_W +: LVL_W]   = LVL_W'(lvl[q]);
            af_offset[q*LVL_W +: LVL_W] = LVL_W'(afo[q]);
            ae_offset[q*LVL_W +: LVL_W] = LVL_W'(aeo[q]);
        end
    endtask

    task automatic randomize_queues();
        for (int q = 0; q < NUM_Q; q++) begin
            int k = int'($urandom % 4);
            int d = int'($urandom % 3) - 1;
            afo[q] = int'($urandom_range(0, 80));
            aeo[q] = int'($urandom_range(0, 80));
            case (k)
                0: lvl[q] = QCAP - afo[q] + d;
                1: lvl[q] = aeo[q] + d;
                2: lvl[q] = int'($urandom_range(0, 1023));
                default: lvl[q] = int'($urandom_range(0, QCAP));
            endcase
            if (lvl[q] < 0) lvl[q] = 0;
            if (lvl[q] > 1023) lvl[q] = 1023;
        end
        drive();
    endtask

    task automatic tick(input bit w, input bit r);
        #5;
        if (w) wr_clk = 1;
        if (r) rd_clk = 1;
        #5;
        wr_clk = 0;
        rd_clk = 0;
    endtask

    // One edge on the chosen clocks, with expectations from the bench model.
    task automatic step(input bit w, input bit r, input string tag);
        if (w) begin
            e_af_sec = direct_mode ? int'(wr_sector_sel) : wptr;
            e_af_bus = exp_bus(1, e_af_sec);
            if (!direct_mode) wptr = (wptr + 1) % NUM_SEC;
        end
        if (r) begin
            e_ae_sec = direct_mode ? int'(rd_sector_sel) : rptr;
            e_ae_bus = exp_bus(0, e_ae_sec);
            if (!direct_mode) rptr = (rptr + 1) % NUM_SEC;
        end
        tick(w, r);
        chk({tag, " af_bus (R2 R4)"},    int'(af_bus_n),  int'(e_af_bus));
        chk({tag, " af_sector (R4)"},    int'(af_sector), e_af_sec);
        chk({tag, " ae_bus (R3 R4)"},    int'(ae_bus_n),  int'(e_ae_bus));
        chk({tag, " ae_sector (R4)"},    int'(ae_sector), e_ae_sec);
    endtask

    task automatic do_reset(input bit dmode);
        wr_rst = 1;
        rd_rst = 1;
        direct_mode = dmode;
        tick(1, 1);
        tick(1, 1);
        wr_rst = 0;
        rd_rst = 0;
        wptr = 0;
        rptr = 0;
        e_af_bus = '1;
        e_ae_bus = '1;
        e_af_sec = 0;
        e_ae_sec = 0;
        chk("R1 af_bus after reset",    int'(af_bus_n),  'hFF);
        chk("R1 af_sector after reset", int'(af_sector), 0);
        chk("R1 ae_bus after reset",    int'(ae_bus_n),  'hFF);
        chk("R1 ae_sector after reset", int'(ae_sector), 0);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        for (int q = 0; q < NUM_Q; q++) begin
            lvl[q] = 0;
            afo[q] = 0;
            aeo[q] = 0;
        end
        drive();
        do_reset(0);

        // Directed threshold corners: R2 at/over the limit, saturation; R3 at/over.
        afo[0] = 10; lvl[0] = QCAP - 10;
        afo[1] = 10; lvl[1] = QCAP - 11;
        afo[2] = 0;  lvl[2] = 700;
        afo[3] = 0;  lvl[3] = QCAP - 1;
        aeo[8] = 5;  lvl[8] = 5;
        aeo[9] = 5;  lvl[9] = 6;
        aeo[10] = 0; lvl[10] = 0;
        drive();
        for (int i = 0; i < 4; i++) step(1, 1, "R2 R3 corners polled R5");

        // Polled, all queues, random stimulus (R5 R6).
        for (int i = 0; i < 60; i++) begin
            randomize_queues();
            step(1, 1, "R5 R6 polled full");
        end

        // Polled with fewer queues configured (R6 R8).
        foreach (lvl[q]) begin lvl[q] = 0; aeo[q] = 40; afo[q] = 600; end
        drive();
        cfg_qcount = 5'd12;
        for (int i = 0; i < 4; i++) step(1, 1, "R8 cfg12 all active");
        cfg_qcount = 5'd5;
        for (int i = 0; i < 4; i++) step(1, 1, "R6 R8 cfg5 all active");
        cfg_qcount = 5'd0;
        for (int i = 0; i < 4; i++) step(1, 1, "R6 R8 cfg0");
        for (int i = 0; i < 30; i++) begin
            cfg_qcount = QCNT_W'($urandom_range(0, NUM_Q));
            randomize_queues();
            step(1, 1, "R6 R8 polled random cfg");
        end

        // Clock independence (R9): one side ticks alone.
        cfg_qcount = QCNT_W'(NUM_Q);
        for (int i = 0; i < 5; i++) begin
            randomize_queues();
            step(1, 0, "R9 write clock only");
        end
        for (int i = 0; i < 5; i++) begin
            randomize_queues();
            step(0, 1, "R9 read clock only");
        end
        for (int i = 0; i < 20; i++) begin
            randomize_queues();
            step(($urandom % 2) == 0, ($urandom % 2) == 0, "R9 R5 mixed clocks");
        end

        // Direct mode with independent selects (R7).
        do_reset(1);
        for (int i = 0; i < 50; i++) begin
            randomize_queues();
            wr_sector_sel = SEC_W'($urandom % NUM_SEC);
            rd_sector_sel = SEC_W'($urandom % NUM_SEC);
            step(1, 1, "R7 direct");
        end
        wr_sector_sel = '1;
        rd_sector_sel = '0;
        for (int i = 0; i < 3; i++) step(1, 1, "R7 direct opposite sectors");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule